// File: doc/BRIEF.md
# Shared-Exponent Block Quantizer

This block turns a stream of single-precision floating-point words into compact 8-bit blocks. It collects a group of `GROUP` inputs (32 by default) and tracks the largest exponent among them. From that exponent it derives one power-of-two scale for the whole group, stored as an 8-bit code with bias 127 and no mantissa. Every element is divided by that scale and cast to the chosen 8-bit element type.

Three element types are available. The first is an 8-bit float with a 4-bit exponent (bias 7, largest magnitude 448). The second is an 8-bit float with a 5-bit exponent (bias 15, largest magnitude 57344). The third is a signed integer. The group is stored inside the block before any of it is sent, because the scale byte must leave first. Two group buffers are used, so a new group can arrive while the previous one is still being read out. A 32-element block therefore costs 33 bytes, or 8.25 bits per element.

Top module: `mx_block_quant`

## Requirements
- R1: After a group of `GROUP` accepted input words, the output carries exactly `GROUP+1` bytes: the scale code first, then one element byte per input in input order. After the last element, `out_valid` drops unless another group is complete.
- R2: With E the largest biased exponent field (bits 30:23) in the group and no NaN or infinity present, the scale code is E−k when E>k and 0 otherwise. k is 8 for fmt 0, 15 for fmt 1 and 6 for fmt 2 or 3. An all-zero group therefore gets scale code 0x00.
- R3: For fmt 0 and fmt 1, each element is written as {sign, exponent, mantissa}. The exponent field is the input exponent field minus the scale code, plus the element bias (7 or 15). The mantissa is the top 3 or 2 input mantissa bits, truncated. A result below the normal range is encoded as a truncated subnormal.
- R4: For fmt 0, a scaled element whose value lies above 448 in magnitude becomes 0x7E, or 0xFE when negative. This format never emits a NaN code unless the scale is NaN.
- R5: For fmt 2 and 3, each element is the scaled magnitude truncated toward zero, in two's complement. It never equals 0x80.
- R6: An input whose exponent field is 0 (zero or subnormal) gives {sign,7'b0} for the float types and 0x00 for the integer type.
- R7: If any input in a group has exponent field 0xFF, the scale code is 0xFF and every element byte of that group is 0x7F.
- R8: `fmt` is sampled on the beat that accepts the group's final element. Its value on earlier beats has no effect.
- R9: A second group is accepted while the first is still pending or draining. `in_ready` is low only while both group buffers hold undelivered groups.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Element type: 0 = 4-bit-exponent float, 1 = 5-bit-exponent float, 2/3 = signed integer |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| in_data | input | 32 | Single-precision input word |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Scale code or element byte |

## Verification
The bench builds the block with the default group size of 32. Every framing check therefore covers the full 33-byte block and the real wrap of the write and read counters. One table walks each element type through several cases: saturation at the top of the range, truncated subnormals, clamping of the scale to zero, signed zeros, flushed input subnormals and a NaN-poisoned group. Directed runs then fill both buffers before any output is read, which exercises back-pressure. Those runs also change `fmt` on the final beat and stall the output consumer.

// File: rtl/mx_block_quant.sv
module mx_block_quant #(
  parameter int GROUP = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  fmt,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data
);
  localparam int IW = $clog2(GROUP);
  localparam int PW = $clog2(GROUP + 1);

  logic [31:0]   mem [2][GROUP];
  logic [7:0]    scl [2];
  logic [1:0]    fsel [2];
  logic [1:0]    full, full_n;
  logic          wb, rb, nanf;
  logic [IW-1:0] wi;
  logic [PW-1:0] rp;
  logic [7:0]    emx, emax_sel;

  wire [7:0] ex_in   = in_data[30:23];
  wire       acc     = in_valid && in_ready;
  wire       last    = acc && (wi == IW'(GROUP - 1));
  wire [7:0] emx_n   = (ex_in > emx) ? ex_in : emx;
  wire       nan_n   = nanf | (ex_in == 8'hFF);
  wire       o_fire  = out_valid && out_ready;
  wire       o_end   = o_fire && (rp == PW'(GROUP));

  always_comb begin
    case (fmt)
      2'd0:    emax_sel = 8'd8;
      2'd1:    emax_sel = 8'd15;
      default: emax_sel = 8'd6;
    endcase
  end

  wire [7:0] code_n = nan_n ? 8'hFF : ((emx_n > emax_sel) ? emx_n - emax_sel : 8'd0);

  always_comb begin
    full_n = full;
    if (o_end) full_n[rb] = 1'b0;
    if (last)  full_n[wb] = 1'b1;
  end

  assign in_ready  = !full[wb];
  assign out_valid = full[rb];

  always_ff @(posedge clk)
    if (acc) mem[wb][wi] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= '0; wb <= 1'b0; rb <= 1'b0; wi <= '0; rp <= '0;
      emx <= '0; nanf <= 1'b0;
      scl[0] <= '0; scl[1] <= '0; fsel[0] <= '0; fsel[1] <= '0;
    end else begin
      full <= full_n;
      if (acc) begin
        if (last) begin
          wi <= '0; emx <= '0; nanf <= 1'b0;
          scl[wb] <= code_n; fsel[wb] <= fmt; wb <= ~wb;
        end else begin
          wi <= wi + 1'b1; emx <= emx_n; nanf <= nan_n;
        end
      end
      if (o_fire) begin
        if (o_end) begin rp <= '0; rb <= ~rb; end
        else rp <= rp + 1'b1;
      end
    end
  end

  function automatic logic [7:0] cast(input logic [31:0] x, input logic [7:0] c, input logic [1:0] f);
    logic              s;
    logic [7:0]        ex;
    logic [23:0]       sig, t;
    logic signed [9:0] e, be;
    logic [9:0]        sh;
    s   = x[31];
    ex  = x[30:23];
    sig = {1'b1, x[22:0]};
    e   = $signed({2'b00, ex}) - $signed({2'b00, c});
    t   = '0;
    be  = '0;
    sh  = '0;
    if (c == 8'hFF) cast = 8'h7F;
    else if (ex == 8'd0) cast = f[1] ? 8'h00 : {s, 7'b0};
    else if (f == 2'd0) begin
      be = e + 10'sd7;
      if (be >= 10'sd1) begin
        cast = {s, be[3:0], x[22:20]};
        if (be[3:0] == 4'hF && x[22:20] == 3'b111) cast = {s, 7'h7E};
      end else begin
        sh = 10'(10'sd21 - be);
        t = sig >> sh;
        cast = {s, 4'b0, t[2:0]};
      end
    end else if (f == 2'd1) begin
      be = e + 10'sd15;
      if (be >= 10'sd1) cast = {s, be[4:0], x[22:21]};
      else begin
        sh = 10'(10'sd22 - be);
        t = sig >> sh;
        cast = {s, 5'b0, t[1:0]};
      end
    end else begin
      if (e < 10'sd0) cast = 8'h00;
      else begin
        sh = 10'(10'sd23 - e);
        t = sig >> sh;
        cast = s ? 8'(-{1'b0, t[6:0]}) : {1'b0, t[6:0]};
      end
    end
  endfunction

  wire [IW-1:0] ri = (rp == '0) ? '0 : IW'(rp - 1'b1);
  assign out_data = (rp == '0) ? scl[rb] : cast(mem[rb][ri], scl[rb], fsel[rb]);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rp <= PW'(GROUP));
  assert_no_nan_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && rp != '0 && fsel[rb] == 2'd0 && scl[rb] != 8'hFF |-> out_data[6:0] != 7'h7F);
  assert_int_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && rp != '0 && fsel[rb][1] |-> out_data != 8'h80);
  assert_nan_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && rp != '0 && scl[rb] == 8'hFF |-> out_data == 8'h7F);
endmodule

// File: tb/mx_block_quant_tb.sv
module mx_block_quant_tb;
  localparam int GROUP = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fmt = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid;
  logic [7:0] out_data;
  int errors = 0, checks = 0, cyc = 0;

  mx_block_quant #(.GROUP(GROUP)) u_dut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  always #5 clk = ~clk;

  // {fmt, word0, word1, scale, elem0, elem1}; other words are zero
  localparam logic [95:0] VEC [10] = '{
    {8'd0, 32'h43E00000, 32'h3F800000, 8'h7F, 8'h7E, 8'h38},
    {8'd0, 32'h43F00000, 32'hC0200000, 8'h7F, 8'h7E, 8'hC2},
    {8'd1, 32'h3F800000, 32'h30800000, 8'h70, 8'h78, 8'h02},
    {8'd2, 32'h42C80000, 32'hC0700000, 8'h7F, 8'h64, 8'hFD},
    {8'd0, 32'h02800000, 32'h80000000, 8'h00, 8'h60, 8'h80},
    {8'd0, 32'h43E00000, 32'h3B000000, 8'h7F, 8'h7E, 8'h01},
    {8'd1, 32'h7FC00000, 32'h3F800000, 8'hFF, 8'h7F, 8'h7F},
    {8'd0, 32'h00400000, 32'h80000001, 8'h00, 8'h00, 8'h80},
    {8'd2, 32'h42FF0000, 32'h3F400000, 8'h7F, 8'h7F, 8'h00},
    {8'd0, 32'h00000000, 32'h00000000, 8'h00, 8'h00, 8'h00}
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d, input logic [1:0] f);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; fmt = f;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic pull(output logic [7:0] b);
    @(negedge clk);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    b = out_data;
    @(posedge clk); #1 out_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [7:0] b, held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "reset in_ready R9", in_ready, 1);
    check(out_valid == 1'b0, "reset out_valid R1", out_valid, 0);

    for (int v = 0; v < 10; v++) begin
      push(VEC[v][87:56], VEC[v][89:88]);
      push(VEC[v][55:24], VEC[v][89:88]);
      for (int i = 2; i < GROUP; i++) push(32'h0, VEC[v][89:88]);
      pull(b);
      check(b == VEC[v][23:16], $sformatf("vec%0d scale R2/R7", v), b, VEC[v][23:16]);
      pull(b);
      check(b == VEC[v][15:8], $sformatf("vec%0d elem0 R3/R4/R5/R6", v), b, VEC[v][15:8]);
      pull(b);
      check(b == VEC[v][7:0], $sformatf("vec%0d elem1 R3/R5/R6", v), b, VEC[v][7:0]);
      for (int i = 2; i < GROUP; i++) begin
        pull(b);
        check(b == ((VEC[v][23:16] == 8'hFF) ? 8'h7F : 8'h00),
              $sformatf("vec%0d elem%0d R6/R7", v, i), b, (VEC[v][23:16] == 8'hFF) ? 8'h7F : 8'h00);
      end
      @(negedge clk);
      check(out_valid == 1'b0, $sformatf("vec%0d frame end R1", v), out_valid, 0);
    end

    // R9: two groups accepted with no output read; R8: fmt taken on last beat
    for (int i = 0; i < GROUP; i++) push(32'h3F800000, 2'd0);
    for (int i = 0; i < GROUP; i++) push(32'h3F800000, (i == GROUP - 1) ? 2'd2 : 2'd0);
    @(negedge clk);
    check(in_ready == 1'b0, "both full R9", in_ready, 0);
    check(out_valid == 1'b1, "pending R9", out_valid, 1);

    // R10: stall holds data
    held = out_data;
    repeat (3) @(negedge clk);
    check(out_data == held && out_valid, "stall hold R10", out_data, held);

    pull(b);
    check(b == 8'h77, "group A scale R2", b, 8'h77);
    for (int i = 0; i < GROUP; i++) begin
      pull(b);
      check(b == 8'h78, "group A elem R3", b, 8'h78);
    end
    @(negedge clk);
    check(in_ready == 1'b1, "buffer freed R9", in_ready, 1);
    pull(b);
    check(b == 8'h79, "group B scale R8", b, 8'h79);
    for (int i = 0; i < GROUP; i++) begin
      pull(b);
      check(b == 8'h40, "group B elem R8/R5", b, 8'h40);
    end
    @(negedge clk);
    check(out_valid == 1'b0, "drained R1", out_valid, 0);
    finish_run();
  end
endmodule